// File: doc/BRIEF.md
# Auto-Increment Word Programming Sequencer

This block sits behind the SPI slave front end of a serial flash model and runs the word-pair programming session with an automatically advancing address. The front end hands it one pulse when chip select falls, one pulse when chip select rises, and each received byte in turn. The status register unit supplies the write-enable latch and a protection verdict for the address on `tgt_addr_o`. The block opens the session, issues two byte writes per command to a plain memory write port, and models the self-timed program delay with a cycle counter. It also screens commands during a session and can drive the data-out pin as a ready/busy line.

The opening command is opcode ADh, a 24-bit address and two data bytes. Each later command in the same session is ADh and two data bytes only. The write pointer steps by two after each pair. The session ends when write-disable (04h) is received, or on its own once the last unprotected word, or the top of the address space, has been programmed. Opcode 70h selects hardware busy signalling and 80h deselects it. Both are honoured only when no session is open.

Top module: `aai_word_seq`

## Requirements
- R1: After reset `aai_o`, `busy_o`, `hw_mode_o`, `wr_en_o`, `so_oe_o` and `wel_clr_o` are all 0.
- R2: A frame of ADh, three address bytes (most significant first) and two data bytes, ended by a chip-select rise while `wel_i`=1, `prot_i`=0 for the frame address and the block is not busy, sets `aai_o` to 1 in the next cycle.
- R3: Each accepted command writes its first data byte to the pointer with bit 0 cleared, then in the next cycle writes its second byte to the same word with bit 0 set. The pair starts the cycle after the chip-select rise, and the pointer then steps by 2. A command inside a session carries no address.
- R4: An ADh frame received while `wel_i`=0, or while `prot_i`=1 for the frame address, starts no session and issues no write.
- R5: `busy_o` is 1 for exactly PROG_CYC+1 cycles after an accepted command. An ADh arriving while `busy_o`=1 is ignored.
- R6: While a session is open and chip select is low after an opcode, `cmd_block_o`=1 unless the opcode is ADh, 04h, or 05h with hardware mode off. Otherwise it is 0.
- R7: Opcode 70h sets `hw_mode_o` and 80h clears it, only when `aai_o`=0. Inside a session both are ignored.
- R8: With `hw_mode_o`=1 and a session open, chip select low drives `so_oe_o`=1, with `so_o`=0 while busy and 1 when ready. A chip-select rise returns `so_oe_o` to 0.
- R9: A 04h frame clears `aai_o`, which ends the session.
- R10: When a completed pair leaves the pointer on a protected address or wraps it past the top, `wel_clr_o` pulses for one cycle and `aai_o` drops. The pointer never wraps into a new pair.
- R11: An ADh frame ending before both data bytes have arrived issues no write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cs_fall_i | input | 1 | Pulse: chip select went low |
| cs_rise_i | input | 1 | Pulse: chip select went high |
| byte_vld_i | input | 1 | A received byte is present |
| byte_i | input | 8 | Received byte |
| wel_i | input | 1 | Write-enable latch state |
| prot_i | input | 1 | Address on tgt_addr_o is protected |
| tgt_addr_o | output | ADDR_W | Address under protection check |
| aai_o | output | 1 | Session-active mode flag |
| hw_mode_o | output | 1 | Hardware busy signalling selected |
| busy_o | output | 1 | Program operation in progress |
| cmd_block_o | output | 1 | Current opcode is not allowed in the session |
| wr_en_o | output | 1 | Memory byte write strobe |
| wr_addr_o | output | ADDR_W | Memory write address |
| wr_data_o | output | 8 | Memory write data |
| wel_clr_o | output | 1 | Pulse: clear the write-enable latch |
| so_o | output | 1 | Ready/busy level for data-out |
| so_oe_o | output | 1 | Data-out drive enable |

## Verification
The hardest case to reach is the automatic end of a session. It needs a session that has already advanced to the last word below a protected region, or to the very top of the address space, and a pair that has completed there. The stimulus opens sessions directly at address 1FEh under a protection boundary at 200h, and at FFFFFEh with no protection. One pair then crosses the limit. Hardware busy signalling is reached by issuing 70h outside a session and then lowering chip select while the program timer still runs.

// File: rtl/aai_pkg.sv
package aai_pkg;
  localparam int BYTE_W = 8;
  localparam logic [BYTE_W-1:0] OP_AAI    = 8'hAD;
  localparam logic [BYTE_W-1:0] OP_WRDI   = 8'h04;
  localparam logic [BYTE_W-1:0] OP_RDSR   = 8'h05;
  localparam logic [BYTE_W-1:0] OP_HW_ON  = 8'h70;
  localparam logic [BYTE_W-1:0] OP_HW_OFF = 8'h80;
endpackage

// File: rtl/aai_frame_rx.sv
module aai_frame_rx
  import aai_pkg::*;
#(
  parameter int ADDR_W = 24,
  localparam int AB    = ADDR_W / 8,
  localparam int MAXB  = AB + 3,
  localparam int CNT_W = $clog2(MAXB + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cs_fall_i,
  input  logic              byte_vld_i,
  input  logic [BYTE_W-1:0] byte_i,
  input  logic              in_sess_i,
  output logic [BYTE_W-1:0] op_o,
  output logic [CNT_W-1:0]  nbyte_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic [BYTE_W-1:0] d0_o,
  output logic [BYTE_W-1:0] d1_o
);
  localparam logic [CNT_W-1:0] MAX_N    = CNT_W'(MAXB);
  localparam logic [CNT_W-1:0] LAST_A   = CNT_W'(AB);
  localparam logic [CNT_W-1:0] D0_FIRST = CNT_W'(AB + 1);
  localparam logic [CNT_W-1:0] D0_SESS  = CNT_W'(1);

  logic [CNT_W-1:0] n_q, d0_idx;

  // data position depends on whether an address is expected
  assign d0_idx  = in_sess_i ? D0_SESS : D0_FIRST;
  assign nbyte_o = n_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      n_q    <= '0;
      op_o   <= '0;
      addr_o <= '0;
      d0_o   <= '0;
      d1_o   <= '0;
    end else if (cs_fall_i) begin
      n_q <= '0;
    end else if (byte_vld_i) begin
      if (n_q == '0) op_o <= byte_i;
      if (!in_sess_i && n_q != '0 && n_q <= LAST_A)
        addr_o <= {addr_o[ADDR_W-BYTE_W-1:0], byte_i};
      if (n_q == d0_idx) d0_o <= byte_i;
      if (n_q == d0_idx + CNT_W'(1)) d1_o <= byte_i;
      if (n_q != MAX_N) n_q <= n_q + CNT_W'(1);
    end
  end
endmodule

// File: rtl/aai_prog_timer.sv
module aai_prog_timer
  import aai_pkg::*;
#(
  parameter int ADDR_W   = 24,
  parameter int PROG_CYC = 16,
  localparam int CNT_W   = (PROG_CYC > 2) ? $clog2(PROG_CYC) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [BYTE_W-1:0] d0_i,
  input  logic [BYTE_W-1:0] d1_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              wr_en_o,
  output logic [ADDR_W-1:0] wr_addr_o,
  output logic [BYTE_W-1:0] wr_data_o
);
  localparam logic [CNT_W-1:0] LAST  = CNT_W'(PROG_CYC - 1);
  localparam logic [CNT_W-1:0] LAST2 = CNT_W'(PROG_CYC - 2);

  logic              busy_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [ADDR_W-1:0] a_q;
  logic [BYTE_W-1:0] d0_q, d1_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
      a_q    <= '0;
      d0_q   <= '0;
      d1_q   <= '0;
    end else if (start_i) begin
      busy_q <= 1'b1;
      cnt_q  <= LAST;
      a_q    <= addr_i;
      d0_q   <= d0_i;
      d1_q   <= d1_i;
    end else if (busy_q) begin
      if (cnt_q == '0) busy_q <= 1'b0;
      else             cnt_q  <= cnt_q - CNT_W'(1);
    end
  end

  assign busy_o    = busy_q;
  assign done_o    = busy_q && cnt_q == '0;
  assign wr_en_o   = busy_q && (cnt_q == LAST || cnt_q == LAST2);
  assign wr_addr_o = {a_q[ADDR_W-1:1], cnt_q != LAST};
  assign wr_data_o = (cnt_q == LAST) ? d0_q : d1_q;

  AST_START_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |-> !busy_q); // R5
  AST_PAIR_ORDER: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_o && !wr_addr_o[0]) |=>
      (wr_en_o && wr_addr_o[0] && wr_addr_o[ADDR_W-1:1] == $past(wr_addr_o[ADDR_W-1:1]))); // R3
endmodule

// File: rtl/aai_mode_ctl.sv
module aai_mode_ctl
  import aai_pkg::*;
#(
  parameter int ADDR_W = 24,
  parameter int CNT_W  = 3,
  localparam int AB    = ADDR_W / 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cs_fall_i,
  input  logic              cs_rise_i,
  input  logic [BYTE_W-1:0] op_i,
  input  logic [CNT_W-1:0]  nbyte_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wel_i,
  input  logic              prot_i,
  input  logic              busy_i,
  input  logic              done_i,
  output logic              aai_o,
  output logic              hw_o,
  output logic              busy_all_o,
  output logic              start_o,
  output logic [ADDR_W-1:0] start_addr_o,
  output logic [ADDR_W-1:0] tgt_addr_o,
  output logic              wel_clr_o,
  output logic              cmd_block_o,
  output logic              so_o,
  output logic              so_oe_o
);
  localparam logic [CNT_W-1:0] N_SESS  = CNT_W'(3);
  localparam logic [CNT_W-1:0] N_FIRST = CNT_W'(AB + 3);

  logic              aai_q, hw_q, cs_act_q, chk_q, wrap_q;
  logic [ADDR_W-1:0] ptr_q;
  logic              cmd_end, has_op, full, sess_end, allowed;

  assign busy_all_o = busy_i | chk_q;
  assign cmd_end    = cs_rise_i & cs_act_q;
  assign has_op     = nbyte_i != '0;
  assign full       = nbyte_i >= (aai_q ? N_SESS : N_FIRST);
  assign tgt_addr_o = aai_q ? ptr_q : addr_i;
  assign start_addr_o = {tgt_addr_o[ADDR_W-1:1], 1'b0};
  assign start_o    = cmd_end && op_i == OP_AAI && full && wel_i &&
                      !busy_all_o && (aai_q || !prot_i);
  // limit reached: next word protected or pointer wrapped
  assign sess_end   = chk_q && aai_q && (wrap_q || prot_i);
  assign wel_clr_o  = sess_end;

  assign allowed = op_i == OP_AAI || op_i == OP_WRDI || (op_i == OP_RDSR && !hw_q);
  assign cmd_block_o = aai_q && cs_act_q && has_op && !allowed;
  assign so_oe_o = hw_q && aai_q && cs_act_q;
  assign so_o    = !busy_all_o;
  assign aai_o   = aai_q;
  assign hw_o    = hw_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      aai_q    <= 1'b0;
      hw_q     <= 1'b0;
      cs_act_q <= 1'b0;
      chk_q    <= 1'b0;
      wrap_q   <= 1'b0;
      ptr_q    <= '0;
    end else begin
      if (cs_fall_i)      cs_act_q <= 1'b1;
      else if (cs_rise_i) cs_act_q <= 1'b0;
      chk_q <= done_i;
      if (start_o) begin
        aai_q <= 1'b1;
        ptr_q <= start_addr_o;
      end else if (done_i) begin
        ptr_q  <= ptr_q + ADDR_W'(2);
        wrap_q <= &ptr_q[ADDR_W-1:1];
      end
      if (sess_end || (cmd_end && has_op && op_i == OP_WRDI)) aai_q <= 1'b0;
      if (cmd_end && has_op && !aai_q) begin
        if (op_i == OP_HW_ON)  hw_q <= 1'b1;
        if (op_i == OP_HW_OFF) hw_q <= 1'b0;
      end
    end
  end

  AST_HW_LOCKED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    aai_q |=> $stable(hw_q)); // R7
  AST_PTR_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    aai_q |=> (ptr_q == $past(ptr_q) || ptr_q == $past(ptr_q) + ADDR_W'(2))); // R3
  AST_END_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wel_clr_o |=> !aai_q); // R10
  AST_OPEN_NEEDS_WEL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(aai_q) |-> ($past(wel_i) && !$past(busy_all_o))); // R4
endmodule

// File: rtl/aai_word_seq.sv
module aai_word_seq
  import aai_pkg::*;
#(
  parameter int ADDR_W   = 24,
  parameter int PROG_CYC = 16,
  localparam int CNT_W   = $clog2(ADDR_W / 8 + 4)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cs_fall_i,
  input  logic              cs_rise_i,
  input  logic              byte_vld_i,
  input  logic [7:0]        byte_i,
  input  logic              wel_i,
  input  logic              prot_i,
  output logic [ADDR_W-1:0] tgt_addr_o,
  output logic              aai_o,
  output logic              hw_mode_o,
  output logic              busy_o,
  output logic              cmd_block_o,
  output logic              wr_en_o,
  output logic [ADDR_W-1:0] wr_addr_o,
  output logic [7:0]        wr_data_o,
  output logic              wel_clr_o,
  output logic              so_o,
  output logic              so_oe_o
);
  logic [BYTE_W-1:0] op, d0, d1;
  logic [CNT_W-1:0]  nbyte;
  logic [ADDR_W-1:0] frm_addr, start_addr;
  logic              start, done, tmr_busy, aai;

  assign aai_o = aai;

  aai_frame_rx #(.ADDR_W(ADDR_W)) u_rx (
    .clk_i, .rst_ni, .cs_fall_i, .byte_vld_i, .byte_i,
    .in_sess_i(aai), .op_o(op), .nbyte_o(nbyte), .addr_o(frm_addr),
    .d0_o(d0), .d1_o(d1)
  );

  aai_prog_timer #(.ADDR_W(ADDR_W), .PROG_CYC(PROG_CYC)) u_tmr (
    .clk_i, .rst_ni, .start_i(start), .addr_i(start_addr), .d0_i(d0), .d1_i(d1),
    .busy_o(tmr_busy), .done_o(done), .wr_en_o, .wr_addr_o, .wr_data_o
  );

  aai_mode_ctl #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_ctl (
    .clk_i, .rst_ni, .cs_fall_i, .cs_rise_i, .op_i(op), .nbyte_i(nbyte),
    .addr_i(frm_addr), .wel_i, .prot_i, .busy_i(tmr_busy), .done_i(done),
    .aai_o(aai), .hw_o(hw_mode_o), .busy_all_o(busy_o), .start_o(start),
    .start_addr_o(start_addr), .tgt_addr_o, .wel_clr_o, .cmd_block_o,
    .so_o, .so_oe_o
  );
endmodule

// File: tb/aai_word_seq_test.sv
module aai_word_seq_test;
  localparam int PC = 12;
  localparam int AB = 3;

  logic clk_i = 0, rst_ni = 0;
  logic cs_fall_i = 0, cs_rise_i = 0, byte_vld_i = 0, wel_i = 0;
  logic [7:0] byte_i = 0;
  logic prot_i;
  logic [23:0] tgt_addr_o, wr_addr_o;
  logic [7:0] wr_data_o;
  logic aai_o, hw_mode_o, busy_o, cmd_block_o, wr_en_o, wel_clr_o, so_o, so_oe_o;
  int prot_base = 32'h0100_0000;
  int checks = 0, fails = 0, cyc = 0;
  logic [31:0] wlog[$];

  always #5 clk_i = ~clk_i;
  assign prot_i = (int'(tgt_addr_o) >= prot_base);

  aai_word_seq #(.ADDR_W(24), .PROG_CYC(PC)) uut (.*);

  // ---------- behavioural reference ----------
  bit m_aai, m_hw, m_cs, m_chk, m_wrap;
  int m_left, m_n;
  logic [7:0] m_op, m_d0, m_d1, m_wd0, m_wd1;
  logic [23:0] m_addr, m_ptr, m_wa;

  function automatic logic [23:0] m_tgt();
    return m_aai ? m_ptr : m_addr;
  endfunction

  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      m_aai = 0; m_hw = 0; m_cs = 0; m_chk = 0; m_wrap = 0; m_left = 0; m_n = 0;
      m_op = 0; m_d0 = 0; m_d1 = 0; m_wd0 = 0; m_wd1 = 0; m_addr = 0; m_ptr = 0; m_wa = 0;
    end else begin
      bit o_aai, busy, done, prot, start, clr;
      int dix;
      o_aai = m_aai; busy = (m_left > 0) || m_chk; done = (m_left == 1);
      prot = int'(m_tgt()) >= prot_base;
      start = 0; clr = 0;
      if (m_chk && m_aai && (m_wrap || prot)) clr = 1;
      if (cs_rise_i && m_cs && m_n >= 1) begin
        if (m_op == 8'hAD && m_n >= (o_aai ? 3 : AB + 3) && wel_i && !busy && (o_aai || !prot))
          start = 1;
        if (m_op == 8'h04) clr = 1;
        if (!o_aai && m_op == 8'h70) m_hw = 1;
        if (!o_aai && m_op == 8'h80) m_hw = 0;
      end
      if (m_left > 0) m_left--;
      m_chk = done;
      if (start) begin
        m_ptr = (o_aai ? m_ptr : m_addr) & 24'hFFFFFE;
        m_wa = m_ptr; m_wd0 = m_d0; m_wd1 = m_d1; m_left = PC; m_aai = 1;
      end else if (done) begin
        m_wrap = (m_ptr[23:1] == 23'h7FFFFF);
        m_ptr = m_ptr + 24'd2;
      end
      if (clr) m_aai = 0;
      if (cs_fall_i) begin m_cs = 1; m_n = 0; end
      else if (cs_rise_i) m_cs = 0;
      if (byte_vld_i && !cs_fall_i) begin
        dix = o_aai ? 1 : AB + 1;
        if (m_n == 0) m_op = byte_i;
        if (!o_aai && m_n >= 1 && m_n <= AB) m_addr = {m_addr[15:0], byte_i};
        if (m_n == dix) m_d0 = byte_i;
        if (m_n == dix + 1) m_d1 = byte_i;
        if (m_n < AB + 3) m_n++;
      end
    end
  end

  task automatic cmp(string tag, string nm, logic [31:0] got, logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s %s got=%h exp=%h t=%0t", tag, nm, got, exp, $time);
    end
  endtask

  always @(negedge clk_i) if (rst_ni) begin
    bit e_busy, e_wr, e_blk;
    e_busy = (m_left > 0) || m_chk;
    e_wr = (m_left == PC) || (m_left == PC - 1);
    e_blk = m_aai && m_cs && m_n >= 1 &&
            !(m_op == 8'hAD || m_op == 8'h04 || (m_op == 8'h05 && !m_hw));
    cmp("R2", "aai_o", 32'(aai_o), 32'(m_aai));
    cmp("R7", "hw_mode_o", 32'(hw_mode_o), 32'(m_hw));
    cmp("R5", "busy_o", 32'(busy_o), 32'(e_busy));
    cmp("R3", "tgt_addr_o", 32'(tgt_addr_o), 32'(m_tgt()));
    cmp("R3", "wr_en_o", 32'(wr_en_o), 32'(e_wr));
    if (e_wr) begin
      cmp("R3", "wr_addr_o", 32'(wr_addr_o), 32'(m_left == PC ? m_wa : (m_wa | 24'h1)));
      cmp("R3", "wr_data_o", 32'(wr_data_o), 32'(m_left == PC ? m_wd0 : m_wd1));
    end
    cmp("R10", "wel_clr_o", 32'(wel_clr_o),
        32'(m_chk && m_aai && (m_wrap || int'(m_tgt()) >= prot_base)));
    cmp("R6", "cmd_block_o", 32'(cmd_block_o), 32'(e_blk));
    cmp("R8", "so_oe_o", 32'(so_oe_o), 32'(m_hw && m_aai && m_cs));
    if (so_oe_o) cmp("R8", "so_o", 32'(so_o), 32'(!e_busy));
    if (wr_en_o) wlog.push_back({wr_addr_o, wr_data_o});
  end

  // ---------- stimulus ----------
  task automatic tick(int n = 1);
    repeat (n) begin @(negedge clk_i); #1; end
  endtask
  task automatic cs_lo(); cs_fall_i = 1; tick(); cs_fall_i = 0; endtask
  task automatic cs_hi(); cs_rise_i = 1; tick(); cs_rise_i = 0; endtask
  task automatic put(logic [7:0] b);
    byte_vld_i = 1; byte_i = b; tick(); byte_vld_i = 0;
  endtask
  task automatic op1(logic [7:0] o); cs_lo(); put(o); cs_hi(); endtask
  task automatic first(logic [23:0] a, logic [7:0] x, logic [7:0] y);
    cs_lo(); put(8'hAD); put(a[23:16]); put(a[15:8]); put(a[7:0]); put(x); put(y); cs_hi();
  endtask
  task automatic next(logic [7:0] x, logic [7:0] y);
    cs_lo(); put(8'hAD); put(x); put(y); cs_hi();
  endtask
  task automatic idle(); while (busy_o) tick(); tick(); endtask

  initial begin
    int nb;
    tick(3); rst_ni = 1; tick();
    cmp("R1", "reset", {aai_o, busy_o, hw_mode_o, wr_en_o, so_oe_o, wel_clr_o}, 0);

    // R4: no write enable, then protected target
    first(24'h000101, 8'h11, 8'h22); tick(2);
    cmp("R4", "no_wel", {aai_o, busy_o, 30'(wlog.size())}, 0);
    wel_i = 1; prot_base = 24'h000100;
    first(24'h000101, 8'h11, 8'h22); tick(2);
    cmp("R4", "prot", {aai_o, busy_o, 30'(wlog.size())}, 0);
    prot_base = 32'h0100_0000;

    // R2/R3 open session at odd address
    first(24'h000101, 8'hA1, 8'hB2); tick();
    cmp("R2", "open", 32'(aai_o), 1);
    nb = 1; while (busy_o) begin tick(); nb++; end
    cmp("R5", "busy_len", nb, PC + 1);
    cmp("R3", "pair0", wlog.size() == 2 ? wlog[0] : 0, 32'h000100A1);
    cmp("R3", "pair1", wlog.size() == 2 ? wlog[1] : 0, 32'h000101B2);
    tick();

    // R11 short command
    cs_lo(); put(8'hAD); put(8'h33); cs_hi(); tick(3);
    cmp("R11", "short", wlog.size(), 2);

    // R3 continued, R5 ignored while busy
    next(8'hC3, 8'hD4);
    next(8'hE5, 8'hF6);
    idle();
    cmp("R3", "next_lo", wlog.size() == 4 ? wlog[2] : 0, 32'h000102C3);
    cmp("R5", "busy_ignored", wlog.size(), 4);

    // R6 whitelist in software mode
    cs_lo(); put(8'h03); tick();
    cmp("R6", "read_blocked", 32'(cmd_block_o), 1);
    cs_hi(); cs_lo(); put(8'h05); tick();
    cmp("R6", "rdsr_ok", 32'(cmd_block_o), 0);
    cs_hi();
    // R7 hw-on ignored in session
    op1(8'h70); tick();
    cmp("R7", "hw_locked", 32'(hw_mode_o), 0);
    // R9 exit
    op1(8'h04); tick();
    cmp("R9", "wrdi", 32'(aai_o), 0);

    // R8 hardware busy mode
    op1(8'h70); tick();
    cmp("R7", "hw_on", 32'(hw_mode_o), 1);
    first(24'h000400, 8'h01, 8'h02);
    cs_lo(); tick();
    cmp("R8", "oe_busy", {so_oe_o, so_o}, 2'b10);
    idle();
    cmp("R8", "ready", {so_oe_o, so_o}, 2'b11);
    put(8'h05); tick();
    cmp("R6", "rdsr_hw_blocked", 32'(cmd_block_o), 1);
    cs_hi(); tick();
    cmp("R8", "hiz", 32'(so_oe_o), 0);
    op1(8'h04); op1(8'h80); tick();
    cmp("R7", "hw_off", {aai_o, hw_mode_o}, 0);

    // R10 protection boundary
    prot_base = 24'h000200;
    first(24'h0001FE, 8'h5A, 8'hA5);
    nb = 0;
    while (busy_o) begin if (wel_clr_o) nb++; tick(); end
    tick();
    cmp("R10", "prot_end", {30'(nb), aai_o}, {30'd1, 1'b0});
    next(8'h77, 8'h88); idle();
    cmp("R10", "no_more", wlog.size(), 8);

    // R10 top of space
    prot_base = 32'h0100_0000;
    first(24'hFFFFFE, 8'h9C, 8'hC9);
    idle();
    cmp("R10", "wrap_end", 32'(aai_o), 0);
    cmp("R10", "top_write", wlog.size() == 10 ? wlog[9] : 0, 32'hFFFFFFC9);

    tick(2);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  always @(posedge clk_i) begin
    cyc++;
    if (cyc > 20000) begin
      fails++; checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule